// File: doc/BRIEF.md
# Octal DTR Mode Switch Sequencer

This block sits on the controller side of a serial NOR flash interface. It moves the attached device between single-line SPI (1-1-1) and octal double-transfer-rate (8D-8D-8D). It does this by sending volatile register writes through a generic flash command engine. It then confirms the change by reading the device ID back in the new protocol. Each step is one request to the engine. A request carries an opcode, a register address with its byte count, a dummy-cycle count, a data byte count, write data and the protocol to use. The engine answers each request with one response that carries an error flag and any read data.

A start pulse begins a sequence, and an enable/disable select sampled with it picks the direction. Entering octal DTR takes two one-byte writes in the current protocol and then an ID read in octal DTR. Leaving it takes a single two-byte write, because one-byte transfers are not allowed in octal DTR, and then an ID read in 1-1-1. The returned ID is compared with an expected ID of programmable length. A current-protocol register follows the device, so that later requests go out in the right protocol.

Top module: `odtr_switch`

## Requirements
- R1: An enable sequence first requests a write (opcode 0x81, cmd_write_o=1) of one byte of value 20 (0x14 on cmd_wdata_o[7:0]) to register address 0x01. The request has zero dummy cycles and uses the current protocol.
- R2: The second enable request writes one byte 0xE7 to register address 0x00 with opcode 0x81 and zero dummy cycles, in the current protocol.
- R3: The third enable request reads the ID (opcode 0x9F, cmd_write_o=0) in octal DTR (cmd_proto_o=1) with 8 dummy cycles and no address bytes. Its byte count is the ID length rounded up to an even number.
- R4: A disable sequence first requests one write in octal DTR to register address 0x00 with opcode 0x81, zero dummy cycles and two data bytes. The first byte is 0xFF on cmd_wdata_o[7:0] and the second is 0x1F on cmd_wdata_o[15:8].
- R5: The second disable request reads the ID (opcode 0x9F) in 1-1-1 (cmd_proto_o=0) with no dummy cycles, no address bytes and a byte count equal to the ID length.
- R6: Every register write carries 4 address bytes when addr4_i was high at start, and 3 address bytes otherwise.
- R7: Only the first id_len_i bytes of the ID (1 to 6) are compared. Byte k lies on bits [8k+7:8k] of both rsp_data_i and exp_id_i. A match ends the sequence with ok_o=1 and err_o=0. A mismatch ends it with ok_o=0 and err_o=1. Bytes beyond the length have no effect.
- R8: An engine response with rsp_err_i=1 ends the sequence at once with err_o=1 and ok_o=0. No later request is issued.
- R9: busy_o rises in the cycle after an accepted start and stays high through the single cycle in which done_o is high. ok_o and err_o hold their value until the next start. A start while busy is ignored.
- R10: proto_o is 0 for 1-1-1 and 1 for octal DTR, and it resets to 0. It takes the new mode once the mode-select write gets a response without error, and it does not change otherwise.
- R11: req_valid_o is high for exactly one cycle per step. The next request waits until the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| enable_i | input | 1 | 1 = enter octal DTR, 0 = return to 1-1-1; sampled at start |
| addr4_i | input | 1 | Current address mode is 4 bytes; sampled at start |
| id_len_i | input | 3 | Expected ID length in bytes, 1 to 6 |
| exp_id_i | input | 48 | Expected ID, byte 0 in bits 7:0 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ok_o | output | 1 | Last sequence succeeded |
| err_o | output | 1 | Last sequence failed |
| proto_o | output | 1 | Current protocol: 0 = 1-1-1, 1 = octal DTR |
| req_valid_o | output | 1 | Command request strobe |
| cmd_op_o | output | 8 | Command opcode |
| cmd_addr_o | output | 32 | Register address |
| cmd_naddr_o | output | 3 | Address byte count |
| cmd_ndummy_o | output | 5 | Dummy cycle count |
| cmd_nbytes_o | output | 3 | Data byte count |
| cmd_write_o | output | 1 | 1 = data out, 0 = data in |
| cmd_wdata_o | output | 16 | Write data, first byte in bits 7:0 |
| cmd_proto_o | output | 1 | Protocol of the request |
| rsp_valid_i | input | 1 | Engine response strobe |
| rsp_err_i | input | 1 | Engine reports an error |
| rsp_data_i | input | 48 | Read data, first byte in bits 7:0 |

## Verification
Some properties are checked by assertions on every cycle. done_o only appears while busy, ok and err are never both set, and an engine error forces an error completion in the next cycle. Each request lasts one cycle, an octal read never asks for an odd byte count, the protocol register stays put while idle, and a start while busy changes nothing. The exact opcode, address, payload and protocol of each step, the ID comparison over the chosen length, and where the protocol register ends up after aborted or mismatching runs can only be shown by the bench. It sweeps direction, address width, every ID length, mismatches inside and outside the compared length, and an error injected at each step.

// File: rtl/odtr_pkg.sv
package odtr_pkg;
  localparam int DUMMY_W = 5;
  localparam int NADDR_W = 3;
  localparam int NBYTE_W = 3;

  typedef enum logic {PROTO_1S = 1'b0, PROTO_8D = 1'b1} proto_e;

  localparam logic [7:0] OP_WR_VREG = 8'h81;
  localparam logic [7:0] OP_RD_ID   = 8'h9F;
  localparam logic [7:0] REG_MODE   = 8'h00;
  localparam logic [7:0] REG_DUMMY  = 8'h01;
  localparam logic [7:0] MODE_OCT   = 8'hE7;
  localparam logic [7:0] MODE_SPI   = 8'hFF;
  localparam logic [7:0] DUMMY_DEF  = 8'h1F;

  typedef struct packed {
    logic [7:0]         op;
    logic [7:0]         addr;
    logic [NADDR_W-1:0] naddr;
    logic [DUMMY_W-1:0] ndummy;
    logic [NBYTE_W-1:0] nbytes;
    logic [15:0]        wdata;
    logic               write;
    proto_e             proto;
    logic               mode_wr;
    logic               last;
  } cmd_t;
endpackage

// File: rtl/odtr_step_table.sv
module odtr_step_table
  import odtr_pkg::*;
#(
  parameter int ENA_DUMMY = 20,
  parameter int ID_DUMMY  = 8,
  parameter int LEN_W     = 3
) (
  input  logic             dir_i,
  input  logic [1:0]       step_i,
  input  proto_e           cur_i,
  input  logic             addr4_i,
  input  logic [LEN_W-1:0] len_i,
  output cmd_t             cmd_o
);
  logic [NADDR_W-1:0] aw;
  logic [NBYTE_W-1:0] len_n, len_even;

  assign aw       = addr4_i ? NADDR_W'(4) : NADDR_W'(3);
  assign len_n    = NBYTE_W'(len_i);
  assign len_even = len_n + NBYTE_W'(len_i[0]);

  always_comb begin
    cmd_o = '0;
    if (dir_i) begin
      unique case (step_i)
        2'd0: begin
          cmd_o.op = OP_WR_VREG; cmd_o.addr = REG_DUMMY; cmd_o.naddr = aw;
          cmd_o.nbytes = NBYTE_W'(1); cmd_o.wdata = {8'h00, 8'(ENA_DUMMY)};
          cmd_o.write = 1'b1; cmd_o.proto = cur_i;
        end
        2'd1: begin
          cmd_o.op = OP_WR_VREG; cmd_o.addr = REG_MODE; cmd_o.naddr = aw;
          cmd_o.nbytes = NBYTE_W'(1); cmd_o.wdata = {8'h00, MODE_OCT};
          cmd_o.write = 1'b1; cmd_o.proto = cur_i; cmd_o.mode_wr = 1'b1;
        end
        default: begin
          cmd_o.op = OP_RD_ID; cmd_o.ndummy = DUMMY_W'(ID_DUMMY);
          cmd_o.nbytes = len_even; cmd_o.proto = PROTO_8D; cmd_o.last = 1'b1;
        end
      endcase
    end else begin
      if (step_i == 2'd0) begin
        cmd_o.op = OP_WR_VREG; cmd_o.addr = REG_MODE; cmd_o.naddr = aw;
        cmd_o.nbytes = NBYTE_W'(2); cmd_o.wdata = {DUMMY_DEF, MODE_SPI};
        cmd_o.write = 1'b1; cmd_o.proto = PROTO_8D; cmd_o.mode_wr = 1'b1;
      end else begin
        cmd_o.op = OP_RD_ID; cmd_o.nbytes = len_n; cmd_o.proto = PROTO_1S;
        cmd_o.last = 1'b1;
      end
    end
  end
endmodule

// File: rtl/odtr_id_match.sv
module odtr_id_match #(
  parameter int ID_BYTES = 6,
  parameter int LEN_W    = 3
) (
  input  logic [ID_BYTES*8-1:0] got_i,
  input  logic [ID_BYTES*8-1:0] exp_i,
  input  logic [LEN_W-1:0]      len_i,
  output logic                  match_o
);
  logic [ID_BYTES-1:0] byte_ok;

  for (genvar k = 0; k < ID_BYTES; k++) begin : g_byte
    assign byte_ok[k] = (32'(k) >= 32'(len_i)) ||
                        (got_i[k*8 +: 8] == exp_i[k*8 +: 8]);
  end

  assign match_o = &byte_ok;
endmodule

// File: rtl/odtr_switch.sv
module odtr_switch
  import odtr_pkg::*;
#(
  parameter int ID_BYTES  = 6,
  parameter int ENA_DUMMY = 20,
  parameter int ID_DUMMY  = 8,
  parameter int ADDR_W    = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  enable_i,
  input  logic                  addr4_i,
  input  logic [2:0]            id_len_i,
  input  logic [ID_BYTES*8-1:0] exp_id_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  ok_o,
  output logic                  err_o,
  output logic                  proto_o,
  output logic                  req_valid_o,
  output logic [7:0]            cmd_op_o,
  output logic [ADDR_W-1:0]     cmd_addr_o,
  output logic [2:0]            cmd_naddr_o,
  output logic [4:0]            cmd_ndummy_o,
  output logic [2:0]            cmd_nbytes_o,
  output logic                  cmd_write_o,
  output logic [15:0]           cmd_wdata_o,
  output logic                  cmd_proto_o,
  input  logic                  rsp_valid_i,
  input  logic                  rsp_err_i,
  input  logic [ID_BYTES*8-1:0] rsp_data_i
);
  localparam int LEN_W = 3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e     state_q;
  logic [1:0] step_q;
  logic       dir_q, addr4_q, ok_q, err_q;
  proto_e     proto_q;
  cmd_t       cmd;
  logic       id_match;

  odtr_step_table #(.ENA_DUMMY(ENA_DUMMY), .ID_DUMMY(ID_DUMMY), .LEN_W(LEN_W)) i_table (
    .dir_i  (dir_q),
    .step_i (step_q),
    .cur_i  (proto_q),
    .addr4_i(addr4_q),
    .len_i  (id_len_i),
    .cmd_o  (cmd)
  );

  odtr_id_match #(.ID_BYTES(ID_BYTES), .LEN_W(LEN_W)) i_match (
    .got_i  (rsp_data_i),
    .exp_i  (exp_id_i),
    .len_i  (id_len_i),
    .match_o(id_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      dir_q   <= 1'b0;
      addr4_q <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      proto_q <= PROTO_1S;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          dir_q   <= enable_i;
          addr4_q <= addr4_i;
          step_q  <= '0;
          ok_q    <= 1'b0;
          err_q   <= 1'b0;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (rsp_valid_i) begin
          if (rsp_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else begin
            if (cmd.mode_wr) proto_q <= proto_e'(dir_q);
            if (cmd.last) begin
              ok_q    <= id_match;
              err_q   <= !id_match;
              state_q <= S_DONE;
            end else begin
              step_q  <= step_q + 2'd1;
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_DONE);
  assign ok_o         = ok_q;
  assign err_o        = err_q;
  assign proto_o      = proto_q;
  assign req_valid_o  = (state_q == S_ISSUE);
  assign cmd_op_o     = cmd.op;
  assign cmd_addr_o   = ADDR_W'(cmd.addr);
  assign cmd_naddr_o  = cmd.naddr;
  assign cmd_ndummy_o = cmd.ndummy;
  assign cmd_nbytes_o = cmd.nbytes;
  assign cmd_write_o  = cmd.write;
  assign cmd_wdata_o  = cmd.wdata;
  assign cmd_proto_o  = cmd.proto;

  a_r9_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r7_ok_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && err_o));
  a_r8_err_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && rsp_valid_i && rsp_err_i) |=> (done_o && err_o && !ok_o));
  a_r3_even_octal_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && cmd_proto_o && !cmd_write_o) |-> !cmd_nbytes_o[0]);
  a_r10_proto_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(proto_o));
  a_r11_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(dir_q));
endmodule

// File: tb/test_odtr_switch.sv
module test_odtr_switch;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, enable_i = 1'b0, addr4_i = 1'b0;
  logic [2:0]  id_len_i = 3'd1;
  logic [47:0] exp_id_i = 48'h6B4D90E137C8;
  logic        busy_o, done_o, ok_o, err_o, proto_o, req_valid_o;
  logic [7:0]  cmd_op_o;
  logic [31:0] cmd_addr_o;
  logic [2:0]  cmd_naddr_o, cmd_nbytes_o;
  logic [4:0]  cmd_ndummy_o;
  logic        cmd_write_o, cmd_proto_o;
  logic [15:0] cmd_wdata_o;
  logic        rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
  logic [47:0] rsp_data_i = '0;

  int errors = 0, checks = 0;
  bit model_proto = 1'b0;

  always #10 clk = ~clk;

  odtr_switch i_odtr_switch (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .enable_i(enable_i),
    .addr4_i(addr4_i), .id_len_i(id_len_i), .exp_id_i(exp_id_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .err_o(err_o),
    .proto_o(proto_o), .req_valid_o(req_valid_o), .cmd_op_o(cmd_op_o),
    .cmd_addr_o(cmd_addr_o), .cmd_naddr_o(cmd_naddr_o),
    .cmd_ndummy_o(cmd_ndummy_o), .cmd_nbytes_o(cmd_nbytes_o),
    .cmd_write_o(cmd_write_o), .cmd_wdata_o(cmd_wdata_o),
    .cmd_proto_o(cmd_proto_o), .rsp_valid_i(rsp_valid_i),
    .rsp_err_i(rsp_err_i), .rsp_data_i(rsp_data_i)
  );

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_req(input bit dir, input bit a4, input int len, input int n);
    int aw = a4 ? 4 : 3;
    chk(req_valid_o, 1, "R11 request strobe");
    if (dir && n == 0) begin
      chk(cmd_op_o, 8'h81, "R1 op"); chk(cmd_addr_o, 1, "R1 addr");
      chk(cmd_nbytes_o, 1, "R1 nbytes"); chk(cmd_wdata_o[7:0], 20, "R1 value");
      chk(cmd_ndummy_o, 0, "R1 dummy"); chk(cmd_write_o, 1, "R1 write");
      chk(cmd_proto_o, model_proto, "R1 proto"); chk(cmd_naddr_o, aw, "R6 naddr");
    end else if (dir && n == 1) begin
      chk(cmd_op_o, 8'h81, "R2 op"); chk(cmd_addr_o, 0, "R2 addr");
      chk(cmd_nbytes_o, 1, "R2 nbytes"); chk(cmd_wdata_o[7:0], 8'hE7, "R2 value");
      chk(cmd_ndummy_o, 0, "R2 dummy"); chk(cmd_write_o, 1, "R2 write");
      chk(cmd_proto_o, model_proto, "R2 proto"); chk(cmd_naddr_o, aw, "R6 naddr");
    end else if (dir) begin
      chk(cmd_op_o, 8'h9F, "R3 op"); chk(cmd_write_o, 0, "R3 read");
      chk(cmd_proto_o, 1, "R3 proto"); chk(cmd_ndummy_o, 8, "R3 dummy");
      chk(cmd_naddr_o, 0, "R3 naddr"); chk(cmd_nbytes_o, len + (len % 2), "R3 nbytes");
    end else if (n == 0) begin
      chk(cmd_op_o, 8'h81, "R4 op"); chk(cmd_addr_o, 0, "R4 addr");
      chk(cmd_nbytes_o, 2, "R4 nbytes"); chk(cmd_wdata_o, 16'h1FFF, "R4 payload");
      chk(cmd_ndummy_o, 0, "R4 dummy"); chk(cmd_write_o, 1, "R4 write");
      chk(cmd_proto_o, 1, "R4 proto"); chk(cmd_naddr_o, aw, "R6 naddr");
    end else begin
      chk(cmd_op_o, 8'h9F, "R5 op"); chk(cmd_write_o, 0, "R5 read");
      chk(cmd_proto_o, 0, "R5 proto"); chk(cmd_ndummy_o, 0, "R5 dummy");
      chk(cmd_naddr_o, 0, "R5 naddr"); chk(cmd_nbytes_o, len, "R5 nbytes");
    end
  endtask

  // corrupt: 0 none, 1 byte inside length, 2 byte beyond length
  task automatic run(input bit dir, input bit a4, input int len, input int corrupt,
                     input int err_step, input bit glitch);
    int nsteps = dir ? 3 : 2;
    int last_exp = (err_step < nsteps) ? err_step : nsteps - 1;
    int mode_step = dir ? 1 : 0;
    bit exp_ok = (err_step >= nsteps) && (corrupt != 1);
    int n = 0;
    bit fin = 0;
    logic [47:0] data;
    @(negedge clk);
    enable_i = dir; addr4_i = a4; id_len_i = 3'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, 1, "R9 busy after start");
    while (!fin) begin
      chk_req(dir, a4, len, n);
      @(negedge clk);
      chk(req_valid_o, 0, "R11 single strobe");
      if (glitch && n == 0) begin start_i = 1'b1; enable_i = !dir; addr4_i = !a4; end
      @(negedge clk);
      start_i = 1'b0; enable_i = dir; addr4_i = a4;
      chk(req_valid_o, 0, "R11 wait for response");
      data = exp_id_i;
      for (int k = len; k < 6; k++) data[k*8 +: 8] = 8'hA5;
      if (corrupt == 1) data[(len-1)*8 +: 8] = data[(len-1)*8 +: 8] ^ 8'h40;
      if (corrupt == 2 && len < 6) data[len*8 +: 8] = exp_id_i[len*8 +: 8] ^ 8'hFF;
      rsp_valid_i = 1'b1; rsp_err_i = (n == err_step); rsp_data_i = data;
      @(negedge clk);
      rsp_valid_i = 1'b0; rsp_err_i = 1'b0;
      if (done_o) fin = 1;
      else begin
        n++;
        if (n > 4) begin
          fin = 1;
          chk(n, last_exp, "R8 runaway sequence");
        end
      end
    end
    chk(n, last_exp, "R8 last issued step");
    chk(busy_o, 1, "R9 busy with done");
    chk(ok_o, exp_ok, "R7 ok");
    chk(err_o, !exp_ok, "R7 err");
    if (err_step > mode_step) model_proto = dir;
    chk(proto_o, model_proto, "R10 protocol");
    @(negedge clk);
    chk(done_o, 0, "R9 done one cycle");
    chk(busy_o, 0, "R9 idle after done");
    chk(ok_o, exp_ok, "R9 ok held");
    chk(err_o, !exp_ok, "R9 err held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o, 0, "R9 reset busy"); chk(done_o, 0, "R9 reset done");
    chk(ok_o, 0, "R9 reset ok"); chk(err_o, 0, "R9 reset err");
    chk(proto_o, 0, "R10 reset protocol"); chk(req_valid_o, 0, "R11 reset strobe");
    rst_ni = 1'b1;
    @(negedge clk);
    for (int len = 1; len <= 6; len++)
      for (int c = 0; c < 3; c++)
        for (int a4 = 0; a4 < 2; a4++)
          for (int d = 1; d >= 0; d--)
            run(d[0], a4[0], len, c, 9, (len == 2 && c == 0));
    for (int d = 1; d >= 0; d--)
      for (int es = 0; es < 3; es++) begin
        if (model_proto != d[0]) run(!d[0], 1'b0, 3, 0, 9, 1'b0);
        run(d[0], 1'b1, 3, 0, es, 1'b0);
      end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule